// File: doc/BRIEF.md
# Flyback Fault Qualifier and UVLO Restart Sequencer

This block decides when a primary-side flyback controller may switch. It takes the per-cycle results of the analog comparators, which are sampled on a cycle strobe. Each fault is qualified by its own rule: a run of consecutive cycles, a window at start-up, a check on the first cycle only, or a millisecond timer. When a fault qualifies, switching stops. The bias request stays at run level so that the VDD capacitor drains to the turn-off threshold. The block then waits for VDD to climb back to the turn-on threshold and tries again.

A soft-short on the output is a constant-current under-voltage condition, held for a whole timer period while in constant-current mode. It sets a latch. While that latch is set, several power-ups pass without any switching. The latch clears on the power-up that follows them. A four-bit code reports the cause of the most recent fault. The code is kept until the next start that actually switches.

Top module: `flyback_fault_seq`

## Requirements
- R1: After reset, sw_en=0, bias_run=0 and fault_code=0. In the idle state, a clock with vdd_on=1 gives sw_en=1, bias_run=1 and fault_code=0 on the next clock. While switching, vdd_low=1 drops both sw_en and bias_run on the next clock and leaves fault_code unchanged.
- R2: ovp_hit set on QUAL_CYC (3) consecutive strobes while switching is a fault with code 4.
- R3: A qualified fault gives sw_en=0 and bias_run=1 on the next clock. In that draining state vdd_on has no effect. vdd_low then gives bias_run=0. fault_code keeps its value until the next start clears it to 0.
- R4: If line_run_ok is not set on any of the first RUN_WIN (3) strobes after a start, the third strobe raises code 2.
- R5: Once line_run_ok has been seen, line_stop_low set on 3 consecutive strobes raises code 5. Strobes before that point are not counted.
- R6: cs_oc_hit set on 3 consecutive strobes raises code 3.
- R7: cs_min_ok=0 on the first strobe after a start raises code 1 at that strobe. On later strobes cs_min_ok is ignored.
- R8: ntc_low set on 3 consecutive strobes raises code 6.
- R9: die_hot=1 while switching raises code 7 on the next clock.
- R10: cc_mode=1 together with ccuv_low=1, held over CCUV_MS (120) ms_tick pulses with no clock in between where either is low, raises code 8 and sets the soft-short latch. A gap in either signal restarts the count.
- R11: While the latch is set, each of the first SKIP_UVLO (3) power-ups gives sw_en=0 and bias_run=1, with code 8 kept. The next power-up clears the latch and starts switching with fault_code=0.
- R12: A strobe on which a counted condition is absent resets that condition's count, so a fault needs a fresh run of 3.
- R13: When several faults qualify on the same clock, the smallest code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vdd_on | input | 1 | VDD at or above the turn-on threshold |
| vdd_low | input | 1 | VDD below the turn-off threshold |
| cyc_stb | input | 1 | One-clock strobe per switching cycle; the comparator flags are valid with it |
| ovp_hit | input | 1 | Output voltage sample above the over-voltage level |
| line_run_ok | input | 1 | Line-sense current above the run threshold |
| line_stop_low | input | 1 | Line-sense current below the stop threshold |
| cs_oc_hit | input | 1 | Current sense crossed the over-current level inside the valid window |
| cs_min_ok | input | 1 | Current sense reached its minimum level in time after drive rose |
| ntc_low | input | 1 | Thermistor pin below its threshold at end of demagnetization |
| ccuv_low | input | 1 | Output sense below the soft-short under-voltage level |
| die_hot | input | 1 | Junction over-temperature |
| cc_mode | input | 1 | Regulation is in constant-current mode |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| sw_en | output | 1 | Switching allowed |
| bias_run | output | 1 | Bias at run level (1) or start-up level (0) |
| fault_code | output | 4 | Cause of the latest fault: 0 none, 1 CS minimum, 2 line start, 3 over-current, 4 over-voltage, 5 line stop, 6 NTC, 7 die hot, 8 soft-short |

## Verification
The hardest state to reach from the ports is the latched soft-short sequence. To get there, the soft-short condition must be held unbroken for the full timer while switching. After that the supply must pass through several drain-and-power-up rounds. The stimulus holds ms_tick high on every clock, so the timer runs at clock rate. It first breaks the condition one tick short of expiry, to show that the count restarts. Then it walks through the skipped power-ups one by one, checking after each that switching stays off, until the one that starts again.

// File: rtl/flyback_fault_pkg.sv
package flyback_fault_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;

  localparam int NUM_FLT = 8;

  typedef enum logic [3:0] {
    FLT_NONE       = 4'd0,
    FLT_CSMIN      = 4'd1,
    FLT_LINE_START = 4'd2,
    FLT_OC         = 4'd3,
    FLT_OVP        = 4'd4,
    FLT_LINE_STOP  = 4'd5,
    FLT_NTC        = 4'd6,
    FLT_DIE_HOT    = 4'd7,
    FLT_CCUV       = 4'd8
  } fault_e;

  // hits[i] stands for code i+1; lowest index wins
  function automatic fault_e pick_fault(input logic [NUM_FLT-1:0] hits);
    fault_e r;
    r = FLT_NONE;
    for (int i = NUM_FLT - 1; i >= 0; i--) begin
      if (hits[i]) r = fault_e'(4'(i + 1));
    end
    return r;
  endfunction

endpackage

// File: rtl/consec_qual.sv
module consec_qual #(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic stb,
  input  logic cond,
  output logic qual
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  assign qual = active & stb & cond & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cnt <= '0;
    end else if (stb) begin
      if (!cond)            cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/start_checks.sv
module start_checks #(
  parameter int RUN_WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic stb,
  input  logic line_run_ok,
  input  logic cs_min_ok,
  output logic csmin_fail,
  output logic start_fail,
  output logic run_seen
);
  localparam int IW = $clog2(RUN_WIN + 1);

  logic [IW-1:0] cyc_idx;
  logic          first_cyc;

  assign first_cyc  = (cyc_idx == '0);
  assign csmin_fail = active & stb & first_cyc & ~cs_min_ok;
  assign start_fail = active & stb & ~run_seen & ~line_run_ok &
                      (cyc_idx == IW'(RUN_WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cyc_idx  <= '0;
      run_seen <= 1'b0;
    end else if (stb) begin
      if (cyc_idx != IW'(RUN_WIN)) cyc_idx <= cyc_idx + 1'b1;
      if (line_run_ok)             run_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/ccuv_timer.sv
module ccuv_timer #(
  parameter int CCUV_MS = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cc_mode,
  input  logic ccuv_low,
  input  logic ms_tick,
  output logic expire
);
  localparam int TW = $clog2(CCUV_MS + 1);
  localparam logic [TW-1:0] LAST = TW'(CCUV_MS - 1);

  logic [TW-1:0] ms_cnt;
  logic          hold;

  assign hold   = active & cc_mode & ccuv_low;
  assign expire = hold & ms_tick & (ms_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !hold) begin
      ms_cnt <= '0;
    end else if (ms_tick && ms_cnt != LAST) begin
      ms_cnt <= ms_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flyback_fault_seq.sv
module flyback_fault_seq
  import flyback_fault_pkg::*;
#(
  parameter int QUAL_CYC  = 3,
  parameter int RUN_WIN   = 3,
  parameter int CCUV_MS   = 120,
  parameter int SKIP_UVLO = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vdd_on,
  input  logic       vdd_low,
  input  logic       cyc_stb,
  input  logic       ovp_hit,
  input  logic       line_run_ok,
  input  logic       line_stop_low,
  input  logic       cs_oc_hit,
  input  logic       cs_min_ok,
  input  logic       ntc_low,
  input  logic       ccuv_low,
  input  logic       die_hot,
  input  logic       cc_mode,
  input  logic       ms_tick,
  output logic       sw_en,
  output logic       bias_run,
  output logic [3:0] fault_code
);
  localparam int NQ = 4;
  localparam int SW = $clog2(SKIP_UVLO + 1);

  seq_state_e    state;
  fault_e        code_q;
  logic          ccuv_latched;
  logic [SW-1:0] skip_cnt;

  logic          active;
  logic          csmin_fail, start_fail, run_seen, ccuv_expire;
  logic [NQ-1:0] q_cond, q_hit;
  logic [NUM_FLT-1:0] hits;
  fault_e        picked;
  logic          fault_take;

  assign active = (state == ST_RUN);

  start_checks #(.RUN_WIN(RUN_WIN)) u_start (
    .clk(clk), .rst_n(rst_n), .active(active), .stb(cyc_stb),
    .line_run_ok(line_run_ok), .cs_min_ok(cs_min_ok),
    .csmin_fail(csmin_fail), .start_fail(start_fail), .run_seen(run_seen)
  );

  // order: over-current, over-voltage, line stop, NTC
  assign q_cond = {ntc_low, line_stop_low & run_seen, ovp_hit, cs_oc_hit};

  genvar g;
  generate
    for (g = 0; g < NQ; g++) begin : g_qual
      consec_qual #(.N(QUAL_CYC)) u_q (
        .clk(clk), .rst_n(rst_n), .active(active), .stb(cyc_stb),
        .cond(q_cond[g]), .qual(q_hit[g])
      );
    end
  endgenerate

  ccuv_timer #(.CCUV_MS(CCUV_MS)) u_ccuv (
    .clk(clk), .rst_n(rst_n), .active(active), .cc_mode(cc_mode),
    .ccuv_low(ccuv_low), .ms_tick(ms_tick), .expire(ccuv_expire)
  );

  assign hits = {ccuv_expire, die_hot & active, q_hit[3], q_hit[2],
                 q_hit[1], q_hit[0], start_fail, csmin_fail};
  assign picked     = pick_fault(hits);
  assign fault_take = active & ~vdd_low & (|hits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_OFF;
      code_q       <= FLT_NONE;
      ccuv_latched <= 1'b0;
      skip_cnt     <= '0;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (vdd_on) begin
            if (ccuv_latched && skip_cnt != SW'(SKIP_UVLO)) begin
              skip_cnt <= skip_cnt + 1'b1;
              state    <= ST_DRAIN;
            end else begin
              ccuv_latched <= 1'b0;
              code_q       <= FLT_NONE;
              state        <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (vdd_low) begin
            state <= ST_OFF;
          end else if (fault_take) begin
            state  <= ST_DRAIN;
            code_q <= picked;
            if (picked == FLT_CCUV) begin
              ccuv_latched <= 1'b1;
              skip_cnt     <= '0;
            end
          end
        end
        ST_DRAIN: begin
          if (vdd_low) state <= ST_OFF;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign sw_en      = (state == ST_RUN);
  assign bias_run   = (state != ST_OFF);
  assign fault_code = code_q;

endmodule

// File: rtl/flyback_fault_chk.sv
module flyback_fault_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_en,
  input logic       bias_run,
  input logic [3:0] fault_code,
  input logic       vdd_low,
  input logic       die_hot,
  input logic       csmin_fail,
  input logic       fault_take,
  input logic       ccuv_latched
);
  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> fault_code == 4'd0);

  // R3
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> (!sw_en && bias_run));

  // R3
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && bias_run && vdd_low) |=> !bias_run);

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en ##1 !sw_en) |-> $stable(fault_code));

  // R7
  csmin_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csmin_fail && !vdd_low) |=> fault_code == 4'd1);

  // R9
  die_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && die_hot && !vdd_low) |=> !sw_en);

  // R11
  latch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccuv_latched |-> !sw_en);
endmodule

bind flyback_fault_seq flyback_fault_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .bias_run(bias_run),
  .fault_code(fault_code), .vdd_low(vdd_low), .die_hot(die_hot),
  .csmin_fail(csmin_fail), .fault_take(fault_take),
  .ccuv_latched(ccuv_latched)
);

// File: tb/flyback_fault_seq_test.sv
module flyback_fault_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vdd_on = 0, vdd_low = 0, cyc_stb = 0, ovp_hit = 0, line_run_ok = 0;
  logic line_stop_low = 0, cs_oc_hit = 0, cs_min_ok = 0, ntc_low = 0;
  logic ccuv_low = 0, die_hot = 0, cc_mode = 0, ms_tick = 0;
  logic sw_en, bias_run;
  logic [3:0] fault_code;

  int checks = 0, errors = 0, wd = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  flyback_fault_seq uut (
    .clk(clk), .rst_n(rst_n), .vdd_on(vdd_on), .vdd_low(vdd_low),
    .cyc_stb(cyc_stb), .ovp_hit(ovp_hit), .line_run_ok(line_run_ok),
    .line_stop_low(line_stop_low), .cs_oc_hit(cs_oc_hit),
    .cs_min_ok(cs_min_ok), .ntc_low(ntc_low), .ccuv_low(ccuv_low),
    .die_hot(die_hot), .cc_mode(cc_mode), .ms_tick(ms_tick),
    .sw_en(sw_en), .bias_run(bias_run), .fault_code(fault_code)
  );

  // behavioural reference: 0 idle, 1 switching, 2 draining
  int m_st, m_ovp, m_oc, m_ntc, m_stop, m_n, m_seen, m_ms, m_lat, m_skip, m_code, f;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_code = 0; m_lat = 0; m_skip = 0;
    end else if (m_st == 0) begin
      if (vdd_on) begin
        if (m_lat != 0 && m_skip < 3) begin
          m_skip++; m_st = 2;
        end else begin
          m_lat = 0; m_st = 1; m_code = 0;
          m_ovp = 0; m_oc = 0; m_ntc = 0; m_stop = 0; m_n = 0; m_seen = 0; m_ms = 0;
        end
      end
    end else if (m_st == 1) begin
      if (vdd_low) m_st = 0;
      else begin
        f = 99;
        if (cyc_stb) begin
          if (m_n == 0 && !cs_min_ok) f = 1;
          if (m_n == 2 && m_seen == 0 && !line_run_ok && f == 99) f = 2;
          m_oc  = cs_oc_hit ? m_oc + 1 : 0;
          if (m_oc >= 3 && f == 99) f = 3;
          m_ovp = ovp_hit ? m_ovp + 1 : 0;
          if (m_ovp >= 3 && f == 99) f = 4;
          if (m_seen != 0) begin
            m_stop = line_stop_low ? m_stop + 1 : 0;
            if (m_stop >= 3 && f == 99) f = 5;
          end
          m_ntc = ntc_low ? m_ntc + 1 : 0;
          if (m_ntc >= 3 && f == 99) f = 6;
          if (line_run_ok) m_seen = 1;
          m_n++;
        end
        if (die_hot && f == 99) f = 7;
        if (cc_mode && ccuv_low) begin
          if (ms_tick) m_ms++;
          if (m_ms >= 120 && f == 99) f = 8;
        end else m_ms = 0;
        if (f != 99) begin
          m_st = 2; m_code = f;
          if (f == 8) begin m_lat = 1; m_skip = 0; end
        end
      end
    end else begin
      if (vdd_low) m_st = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (sw_en !== (m_st == 1) || bias_run !== (m_st != 0) || fault_code !== 4'(m_code)) begin
        errors++;
        $display("FAIL %s model: sw_en=%0b bias_run=%0b code=%0d expected %0b %0b %0d",
                 cur_req, sw_en, bias_run, fault_code, m_st == 1, m_st != 0, m_code);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired in %s: cycles %0d expected below %0d", cur_req, wd, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic st(input string req, input int s, input int b, input int c);
    chk(req, sw_en, s);
    chk(req, bias_run, b);
    chk(req, fault_code, c);
  endtask

  task automatic pwr_up();
    vdd_on = 1; @(negedge clk); vdd_on = 0;
  endtask

  task automatic uvlo();
    vdd_low = 1; @(negedge clk); vdd_low = 0;
  endtask

  task automatic cyc(input logic ov, input logic rn, input logic sp,
                     input logic oc, input logic mn, input logic nt);
    cyc_stb = 1; ovp_hit = ov; line_run_ok = rn; line_stop_low = sp;
    cs_oc_hit = oc; cs_min_ok = mn; ntc_low = nt;
    @(negedge clk);
    cyc_stb = 0; ovp_hit = 0; line_run_ok = 0; line_stop_low = 0;
    cs_oc_hit = 0; cs_min_ok = 0; ntc_low = 0;
  endtask

  task automatic good();
    cyc(0, 1, 0, 0, 1, 0);
  endtask

  task automatic restart();
    uvlo(); pwr_up();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    st("R1 reset state", 0, 0, 0);
    pwr_up();
    st("R1 power-up", 1, 1, 0);
    good(); good();
    uvlo();
    st("R1 plain uvlo", 0, 0, 0);

    cur_req = "R2";
    pwr_up(); good();
    cyc(1, 0, 0, 0, 1, 0); cyc(1, 0, 0, 0, 1, 0);
    st("R2 two ovp still running", 1, 1, 0);
    cyc(1, 0, 0, 0, 1, 0);
    st("R2 ovp fault", 0, 1, 4);

    cur_req = "R3";
    pwr_up();
    st("R3 vdd_on ignored while draining", 0, 1, 4);
    uvlo();
    st("R3 drained code kept", 0, 0, 4);
    pwr_up();
    st("R3 restart clears code", 1, 1, 0);

    cur_req = "R12";
    good();
    cyc(1, 0, 0, 0, 1, 0); cyc(1, 0, 0, 0, 1, 0); good();
    cyc(1, 0, 0, 0, 1, 0); cyc(1, 0, 0, 0, 1, 0);
    st("R12 broken run no fault", 1, 1, 0);
    cyc(1, 0, 0, 0, 1, 0);
    st("R12 fresh run faults", 0, 1, 4);

    cur_req = "R4";
    restart();
    cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
    st("R4 window open", 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    st("R4 no run current", 0, 1, 2);
    restart();
    cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0); cyc(0, 1, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    st("R4 run seen on third", 1, 1, 0);

    cur_req = "R5";
    cyc(0, 0, 1, 0, 1, 0); cyc(0, 0, 1, 0, 1, 0);
    st("R5 two stop", 1, 1, 0);
    cyc(0, 0, 1, 0, 1, 0);
    st("R5 line stop", 0, 1, 5);

    cur_req = "R6";
    restart(); good();
    cyc(0, 0, 0, 1, 1, 0); cyc(0, 0, 0, 1, 1, 0); cyc(0, 0, 0, 1, 1, 0);
    st("R6 over-current", 0, 1, 3);

    cur_req = "R7";
    restart();
    cyc(0, 1, 0, 0, 0, 0);
    st("R7 cs min first cycle", 0, 1, 1);
    restart(); good();
    cyc(0, 0, 0, 0, 0, 0);
    st("R7 cs min later ignored", 1, 1, 0);

    cur_req = "R8";
    cyc(0, 0, 0, 0, 1, 1); cyc(0, 0, 0, 0, 1, 1); cyc(0, 0, 0, 0, 1, 1);
    st("R8 ntc", 0, 1, 6);

    cur_req = "R9";
    restart(); good();
    die_hot = 1; @(negedge clk); die_hot = 0;
    st("R9 die hot", 0, 1, 7);

    cur_req = "R13";
    restart(); good();
    cyc(1, 0, 0, 1, 1, 0); cyc(1, 0, 0, 1, 1, 0); cyc(1, 0, 0, 1, 1, 0);
    st("R13 oc beats ovp", 0, 1, 3);

    cur_req = "R10";
    restart(); good();
    ccuv_low = 1; ms_tick = 1;
    repeat (200) @(negedge clk);
    st("R10 not in cc mode", 1, 1, 0);
    cc_mode = 1;
    repeat (119) @(negedge clk);
    st("R10 one tick short", 1, 1, 0);
    ccuv_low = 0; @(negedge clk); ccuv_low = 1;
    repeat (119) @(negedge clk);
    st("R10 count restarted", 1, 1, 0);
    @(negedge clk);
    st("R10 soft-short fault", 0, 1, 8);
    ccuv_low = 0; cc_mode = 0; ms_tick = 0;

    cur_req = "R11";
    for (int k = 0; k < 3; k++) begin
      uvlo();
      chk("R11 drained", bias_run, 0);
      pwr_up();
      st("R11 skipped power-up", 0, 1, 8);
    end
    uvlo(); pwr_up();
    st("R11 fourth power-up runs", 1, 1, 0);
    good();
    st("R11 latch cleared", 1, 1, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule